// File: doc/BRIEF.md
# Per-Crossing Best-Two Track Selector

The block collects a stream of track candidates that belong to one event and picks winners for each bunch crossing. A candidate has an accept bit, a crossing index, a class bit (0 = collision, 1 = accelerator), a quality and a key-wire number. For every crossing and class the block keeps running trackers as candidates arrive. When the last candidate of the event has been taken, it plays out up to four winners per crossing on a valid/ready output stream.

Each (crossing, class) pair has two trackers. Both follow the highest quality seen. They break quality ties in opposite directions: one keeps the highest key wire, the other keeps the lowest. The first tracker gives the best candidate. If the two trackers disagree, the lowest-wire entry at the top quality is the second-best. If they agree, a third tracker gives the second-best. It holds the strongest candidate strictly below the top quality, and it is kept up to date as the candidates arrive, so no candidate needs to be stored. Once the final winner leaves, all trackers clear and the next event starts from nothing.

Top module: `best2_track_sel`

## Requirements
- R1: After reset `cand_ready` is 1 and `win_valid` is 0.
- R2: A candidate taken with `cand_ok` = 0 has no effect on any winner.
- R3: The best winner of a crossing and class has the highest quality among its accepted candidates. Among equal quality it has the highest key wire.
- R4: Several accepted candidates may share the top quality with at least two distinct key wires. In that case the second winner is the one at the top quality with the lowest key wire.
- R5: In every other case the second winner has the highest quality strictly below the best. Among equal quality it has the highest key wire. If no such candidate exists, there is no second winner.
- R6: Winners leave in ascending crossing order. Within a crossing the order is collision best, collision second, accelerator best, accelerator second. Absent winners are skipped.
- R7: `win_last` is 1 exactly on the final winner of an event. An event with no winners emits nothing.
- R8: From the cycle after the last candidate is taken until the event ends, `cand_ready` is 0. A winner stalled by `win_ready` = 0 holds its fields.
- R9: After the final winner is taken, or after an event with no winners, `cand_ready` returns to 1. The next event is selected without influence from earlier ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cand_valid | input | 1 | Candidate offered |
| cand_ready | output | 1 | Block takes candidates (collect phase) |
| cand_last | input | 1 | Final candidate of the event |
| cand_ok | input | 1 | Candidate takes part in selection |
| cand_bx | input | $clog2(NBX) | Crossing index |
| cand_accel | input | 1 | Class: 0 collision, 1 accelerator |
| cand_qual | input | QUAL_W | Quality |
| cand_wire | input | WIRE_W | Key wire |
| win_valid | output | 1 | Winner offered |
| win_ready | input | 1 | Consumer takes the winner |
| win_last | output | 1 | Final winner of the event |
| win_bx | output | $clog2(NBX) | Winner crossing index |
| win_accel | output | 1 | Winner class |
| win_qual | output | QUAL_W | Winner quality |
| win_wire | output | WIRE_W | Winner key wire |

## Verification
The bench builds the block with four crossings, a 3-bit quality and a 7-bit key wire. With only four crossings, every position in the output order, including the last one, is reached in a short event. With a narrow wire range in the pseudo-random events, quality ties, duplicate entries and rising maxima turn up often. A directed event with a paced `win_ready` covers stalls on winners placed at every slot kind.

// File: rtl/b2s_pkg.sv
package b2s_pkg;
   localparam int NUM_CLASS    = 2;
   localparam int SLOTS_PER_BX = 4;
   // slot position inside a crossing: {class, second}
   typedef enum logic [1:0] {
      SL_COL_BEST = 2'd0,
      SL_COL_SEC  = 2'd1,
      SL_ACC_BEST = 2'd2,
      SL_ACC_SEC  = 2'd3
   } slot_kind_e;
endpackage

// File: rtl/b2s_cell.sv
module b2s_cell #(
   parameter int QUAL_W = 3,
   parameter int WIRE_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              upd,
   input  logic [QUAL_W-1:0] upd_qual,
   input  logic [WIRE_W-1:0] upd_wire,
   output logic              best_vld,
   output logic [QUAL_W-1:0] best_qual,
   output logic [WIRE_W-1:0] best_wire,
   output logic              sec_vld,
   output logic [QUAL_W-1:0] sec_qual,
   output logic [WIRE_W-1:0] sec_wire
);
   // hi: top quality, high-wire tie break; lo: top quality, low-wire tie break
   // sub: strongest strictly below top quality
   logic              hi_v, lo_v, sub_v;
   logic [QUAL_W-1:0] hi_q, lo_q, sub_q;
   logic [WIRE_W-1:0] hi_w, lo_w, sub_w;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_v <= 1'b0;  hi_q <= '0;  hi_w <= '0;
         lo_v <= 1'b0;  lo_q <= '0;  lo_w <= '0;
         sub_v <= 1'b0; sub_q <= '0; sub_w <= '0;
      end else if (clr) begin
         hi_v <= 1'b0;
         lo_v <= 1'b0;
         sub_v <= 1'b0;
      end else if (upd) begin
         if (!hi_v || upd_qual > hi_q || (upd_qual == hi_q && upd_wire > hi_w)) begin
            hi_v <= 1'b1; hi_q <= upd_qual; hi_w <= upd_wire;
         end
         if (!lo_v || upd_qual > lo_q || (upd_qual == lo_q && upd_wire < lo_w)) begin
            lo_v <= 1'b1; lo_q <= upd_qual; lo_w <= upd_wire;
         end
         if (hi_v && upd_qual > hi_q) begin
            sub_v <= 1'b1; sub_q <= hi_q; sub_w <= hi_w;
         end else if (hi_v && upd_qual < hi_q &&
                      (!sub_v || upd_qual > sub_q || (upd_qual == sub_q && upd_wire > sub_w))) begin
            sub_v <= 1'b1; sub_q <= upd_qual; sub_w <= upd_wire;
         end
      end
   end

   logic split;
   assign split     = hi_v && lo_v && (hi_w != lo_w);
   assign best_vld  = hi_v;
   assign best_qual = hi_q;
   assign best_wire = hi_w;
   assign sec_vld   = split ? 1'b1 : sub_v;
   assign sec_qual  = split ? lo_q : sub_q;
   assign sec_wire  = split ? lo_w : sub_w;

   // R4: both trackers hold the same top quality, low-wire one never above
   p_pair_agree_r4: assert property (@(posedge clk) disable iff (!rst_n)
      hi_v |-> (lo_v && lo_q == hi_q && lo_w <= hi_w));
   // R5: the fallback entry is strictly below the best
   p_second_below_r5: assert property (@(posedge clk) disable iff (!rst_n)
      sub_v |-> (hi_v && sub_q < hi_q));
   // R9: clearing empties the trackers
   p_clear_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (!hi_v && !lo_v && !sub_v));
endmodule

// File: rtl/b2s_emit.sv
module b2s_emit #(
   parameter int NSLOT = 64,
   localparam int PW   = $clog2(NSLOT)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [NSLOT-1:0] slot_vld,
   input  logic             out_ready,
   output logic             busy,
   output logic [PW-1:0]    ptr,
   output logic             out_valid,
   output logic             out_last,
   output logic             done
);
   logic later_any, cur_vld, adv;

   always_comb begin
      later_any = 1'b0;
      for (int i = 0; i < NSLOT; i++)
         if (i > int'(ptr) && slot_vld[i]) later_any = 1'b1;
   end

   assign cur_vld   = slot_vld[ptr];
   assign out_valid = busy && cur_vld;
   assign out_last  = out_valid && !later_any;
   assign done      = busy && !later_any && (!cur_vld || out_ready);
   assign adv       = busy && !done && (!cur_vld || out_ready);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         ptr  <= '0;
      end else if (start) begin
         busy <= 1'b1;
         ptr  <= '0;
      end else if (done) begin
         busy <= 1'b0;
         ptr  <= '0;
      end else if (adv) begin
         ptr <= ptr + 1'b1;
      end
   end

   // R9: the final handshake ends the play-out
   p_idle_after_final_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ready && out_last) |=> !busy);
   // R7: nothing offered outside play-out
   p_quiet_when_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !out_valid);
endmodule

// File: rtl/best2_track_sel.sv
module best2_track_sel #(
   parameter int NBX    = 16,
   parameter int QUAL_W = 3,
   parameter int WIRE_W = 7
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cand_valid,
   output logic                   cand_ready,
   input  logic                   cand_last,
   input  logic                   cand_ok,
   input  logic [$clog2(NBX)-1:0] cand_bx,
   input  logic                   cand_accel,
   input  logic [QUAL_W-1:0]      cand_qual,
   input  logic [WIRE_W-1:0]      cand_wire,
   output logic                   win_valid,
   input  logic                   win_ready,
   output logic                   win_last,
   output logic [$clog2(NBX)-1:0] win_bx,
   output logic                   win_accel,
   output logic [QUAL_W-1:0]      win_qual,
   output logic [WIRE_W-1:0]      win_wire
);
   import b2s_pkg::*;

   localparam int BXW   = $clog2(NBX);
   localparam int NSLOT = NBX * SLOTS_PER_BX;
   localparam int PW    = $clog2(NSLOT);

   if (NBX < 2) begin : g_bad_nbx
      $error("best2_track_sel: NBX must be at least 2");
   end
   if (QUAL_W < 1 || WIRE_W < 1) begin : g_bad_width
      $error("best2_track_sel: field widths must be positive");
   end

   logic                          take, busy, done, start;
   logic [PW-1:0]                 ptr;
   logic [NSLOT-1:0]              slot_v;
   logic [NSLOT-1:0][QUAL_W-1:0]  slot_q;
   logic [NSLOT-1:0][WIRE_W-1:0]  slot_w;

   assign cand_ready = !busy;
   assign take       = cand_valid && cand_ready;
   assign start      = take && cand_last;

   for (genvar b = 0; b < NBX; b++) begin : g_bx
      for (genvar c = 0; c < NUM_CLASS; c++) begin : g_cls
         localparam int BI = b * SLOTS_PER_BX + c * 2;
         logic hit;
         assign hit = take && cand_ok && (int'(cand_bx) == b) && (int'(cand_accel) == c);
         b2s_cell #(.QUAL_W(QUAL_W), .WIRE_W(WIRE_W)) u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr       (done),
            .upd       (hit),
            .upd_qual  (cand_qual),
            .upd_wire  (cand_wire),
            .best_vld  (slot_v[BI]),
            .best_qual (slot_q[BI]),
            .best_wire (slot_w[BI]),
            .sec_vld   (slot_v[BI+1]),
            .sec_qual  (slot_q[BI+1]),
            .sec_wire  (slot_w[BI+1])
         );
      end
   end

   b2s_emit #(.NSLOT(NSLOT)) u_emit (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .slot_vld  (slot_v),
      .out_ready (win_ready),
      .busy      (busy),
      .ptr       (ptr),
      .out_valid (win_valid),
      .out_last  (win_last),
      .done      (done)
   );

   slot_kind_e kind;
   assign kind      = slot_kind_e'(ptr[1:0]);
   assign win_bx    = ptr[PW-1:2];
   assign win_accel = (kind == SL_ACC_BEST) || (kind == SL_ACC_SEC);
   assign win_qual  = slot_q[ptr];
   assign win_wire  = slot_w[ptr];

   // R8: a stalled winner keeps its fields
   p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (win_valid && !win_ready) |=> (win_valid && $stable(win_bx) && $stable(win_accel)
                                     && $stable(win_qual) && $stable(win_wire)));
   // R8: no candidates accepted once the event is closed
   p_closed_after_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cand_valid && cand_ready && cand_last) |=> !cand_ready);
endmodule

// File: tb/test_best2_track_sel.sv
module test_best2_track_sel;
   localparam int NBX = 4, QW = 3, WW = 7;
   localparam int BXW = $clog2(NBX);
   localparam int MAXC = 16, MAXW = NBX * 4;

   logic clk = 0, rst_n = 0;
   logic cand_valid = 0, cand_last = 0, cand_ok = 0, cand_accel = 0, win_ready = 0;
   logic [BXW-1:0] cand_bx = '0;
   logic [QW-1:0] cand_qual = '0;
   logic [WW-1:0] cand_wire = '0;
   logic cand_ready, win_valid, win_last, win_accel;
   logic [BXW-1:0] win_bx;
   logic [QW-1:0] win_qual;
   logic [WW-1:0] win_wire;

   best2_track_sel #(.NBX(NBX), .QUAL_W(QW), .WIRE_W(WW)) i_best2_track_sel (.*);

   always #2 clk = ~clk;

   int tests = 0, fails = 0;
   bit finished = 0;

   int ev_n;
   bit ev_ok[MAXC]; int ev_bx[MAXC]; int ev_acc[MAXC]; int ev_q[MAXC]; int ev_w[MAXC];
   int ex_n;
   int ex_bx[MAXW]; int ex_acc[MAXW]; int ex_q[MAXW]; int ex_w[MAXW];
   logic [15:0] lfsr = 16'hACE1;

   task automatic chk(input bit cond, input string tag, input int act, input int exp);
      tests++;
      if (!cond) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic add(input bit ok, input int bx, input int acc, input int q, input int w);
      ev_ok[ev_n] = ok; ev_bx[ev_n] = bx; ev_acc[ev_n] = acc; ev_q[ev_n] = q; ev_w[ev_n] = w;
      ev_n++;
   endtask

   // reference: selection rules written straight from the requirements
   task automatic model();
      ex_n = 0;
      for (int b = 0; b < NBX; b++)
         for (int c = 0; c < 2; c++) begin
            int bq = -1, hw = -1, lw = 1000, sq = -1, sw = -1;
            for (int i = 0; i < ev_n; i++)
               if (ev_ok[i] && ev_bx[i] == b && ev_acc[i] == c && ev_q[i] > bq) bq = ev_q[i];
            if (bq < 0) continue;
            for (int i = 0; i < ev_n; i++)
               if (ev_ok[i] && ev_bx[i] == b && ev_acc[i] == c && ev_q[i] == bq) begin
                  if (ev_w[i] > hw) hw = ev_w[i];
                  if (ev_w[i] < lw) lw = ev_w[i];
               end
            ex_bx[ex_n] = b; ex_acc[ex_n] = c; ex_q[ex_n] = bq; ex_w[ex_n] = hw; ex_n++;
            if (lw != hw) begin
               ex_bx[ex_n] = b; ex_acc[ex_n] = c; ex_q[ex_n] = bq; ex_w[ex_n] = lw; ex_n++;
            end else begin
               for (int i = 0; i < ev_n; i++)
                  if (ev_ok[i] && ev_bx[i] == b && ev_acc[i] == c && ev_q[i] < bq &&
                      (ev_q[i] > sq || (ev_q[i] == sq && ev_w[i] > sw))) begin
                     sq = ev_q[i]; sw = ev_w[i];
                  end
               if (sq >= 0) begin
                  ex_bx[ex_n] = b; ex_acc[ex_n] = c; ex_q[ex_n] = sq; ex_w[ex_n] = sw; ex_n++;
               end
            end
         end
   endtask

   task automatic run_event(input bit stall, input string tag);
      int got = 0;
      bit fin = 0, held = 0;
      int h_bx = 0, h_acc = 0, h_q = 0, h_w = 0;
      model();
      for (int i = 0; i < ev_n; i++) begin
         @(negedge clk);
         if (i == 0) chk(cand_ready === 1'b1, {tag, " R9 ready at event start"}, cand_ready, 1);
         cand_valid = 1; cand_last = (i == ev_n - 1); cand_ok = ev_ok[i];
         cand_bx = BXW'(ev_bx[i]); cand_accel = ev_acc[i][0];
         cand_qual = QW'(ev_q[i]); cand_wire = WW'(ev_w[i]);
      end
      for (int cyc = 0; cyc < 400 && !fin; cyc++) begin
         @(negedge clk);
         cand_valid = 0; cand_last = 0;
         if (held) begin
            chk(win_valid === 1'b1 && int'(win_bx) == h_bx && int'(win_accel) == h_acc &&
                int'(win_qual) == h_q && int'(win_wire) == h_w,
                {tag, " R8 stalled winner held"}, int'(win_wire), h_w);
            held = 0;
         end
         if (cyc > 0 && cand_ready) begin
            fin = 1;
         end else begin
            if (cyc == 0) chk(cand_ready === 1'b0, {tag, " R8 closed after last"}, cand_ready, 0);
            win_ready = stall ? cyc[0] : 1'b1;
            if (win_valid && win_ready) begin
               if (got < ex_n) begin
                  chk(int'(win_bx) == ex_bx[got], {tag, " R6 crossing"}, int'(win_bx), ex_bx[got]);
                  chk(int'(win_accel) == ex_acc[got], {tag, " R6 class"}, int'(win_accel), ex_acc[got]);
                  chk(int'(win_qual) == ex_q[got], {tag, " R3/R5 quality"}, int'(win_qual), ex_q[got]);
                  chk(int'(win_wire) == ex_w[got], {tag, " R3/R4 wire"}, int'(win_wire), ex_w[got]);
               end
               chk(win_last == (got == ex_n - 1), {tag, " R7 last marker"}, win_last, got == ex_n - 1);
               got++;
            end else if (win_valid) begin
               held = 1; h_bx = win_bx; h_acc = win_accel; h_q = win_qual; h_w = win_wire;
            end
         end
      end
      win_ready = 0;
      chk(fin, {tag, " R9 ready returns"}, fin, 1);
      chk(got == ex_n, {tag, " R7 winner count"}, got, ex_n);
      chk(win_valid === 1'b0, {tag, " R7 no extra winner"}, win_valid, 0);
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk(cand_ready === 1'b1, "R1 ready after reset", cand_ready, 1);
      chk(win_valid === 1'b0, "R1 no winner after reset", win_valid, 0);
   endtask

   task automatic t_single();
      ev_n = 0; add(1, 2, 1, 4, 17);
      run_event(0, "single R3 R7");
   endtask

   task automatic t_tie_top();
      ev_n = 0;
      add(1, 1, 0, 5, 3); add(1, 1, 0, 5, 9); add(1, 1, 0, 2, 20); add(1, 1, 0, 5, 6);
      run_event(0, "tie R4");
   endtask

   task automatic t_below();
      ev_n = 0;
      add(1, 0, 0, 5, 10); add(1, 0, 0, 3, 2); add(1, 0, 0, 3, 8); add(1, 0, 0, 1, 30);
      add(1, 0, 1, 6, 4); add(1, 0, 1, 6, 4); add(1, 0, 1, 2, 1);
      add(1, 3, 1, 7, 7); add(1, 3, 1, 7, 7);
      run_event(0, "below R5");
   endtask

   task automatic t_rising();
      ev_n = 0;
      add(1, 2, 0, 2, 5); add(1, 2, 0, 6, 1); add(1, 2, 0, 1, 3); add(1, 2, 0, 4, 0);
      run_event(0, "rising R5");
   endtask

   task automatic t_ignore();
      ev_n = 0;
      add(0, 1, 1, 7, 50); add(1, 1, 1, 3, 4); add(0, 1, 1, 5, 2); add(0, 0, 0, 7, 1);
      run_event(0, "ignore R2");
   endtask

   task automatic t_order();
      ev_n = 0;
      add(1, 3, 1, 1, 1); add(1, 3, 0, 2, 2); add(1, 0, 1, 3, 3); add(1, 2, 0, 4, 4);
      add(1, 0, 0, 5, 5); add(1, 3, 1, 6, 6); add(1, 0, 0, 1, 9); add(1, 3, 0, 2, 0);
      run_event(0, "order R6");
   endtask

   task automatic t_empty();
      ev_n = 0; add(0, 0, 0, 7, 7); add(0, 3, 1, 6, 1);
      run_event(0, "empty R7 R9");
   endtask

   task automatic t_stall();
      ev_n = 0;
      add(1, 0, 0, 4, 2); add(1, 0, 0, 4, 6); add(1, 1, 1, 3, 3); add(1, 1, 1, 1, 8);
      add(1, 3, 0, 7, 0); add(1, 3, 1, 5, 5);
      run_event(1, "stall R8");
   endtask

   task automatic t_random();
      for (int e = 0; e < 8; e++) begin
         ev_n = 0;
         for (int k = 0; k < 12; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            add(lfsr[15:13] != 3'd0, lfsr[1:0], lfsr[2], lfsr[5:3], lfsr[8:6]);
         end
         run_event(e[0], "random R9");
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      t_reset();
      t_single();
      t_tie_top();
      t_below();
      t_rising();
      t_ignore();
      t_order();
      t_empty();
      t_stall();
      t_random();
      if (!finished) begin
         finished = 1;
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         tests++; fails++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule